// File: doc/BRIEF.md
# I2C Controller Interrupt Hub

This block gathers the eight event sources of an I2C controller into a single interrupt line. Each source delivers a one-cycle pulse. The pulse sets a sticky bit in a status register. A per-source mask register selects which latched bits may raise the interrupt. A one-bit gate register then decides whether the line is driven at all.

Software reaches the block through a small word-addressed register port. The port has a write strobe, a 2-bit word address, 32-bit write data and a combinational read-data output. Software clears status bits by writing ones to them. Writing a fixed key value to the key register resets the block's registers and sends a one-cycle reset pulse to the rest of the controller.

Top module: `i2c_irq_hub`

## Requirements
- R1: After `rst_n` is released, the status, mask and gate registers read zero, `irq` is low and `soft_rst_o` is low.
- R2: A one-cycle pulse on `evt_pulse[i]` sets status bit i at the next clock edge. The bit stays set until it is cleared. The bit order is fixed, because other controller logic decodes it:
  - bit 0: arbitration lost
  - bit 1: transmit error or transfer complete
  - bit 2: transmit queue empty
  - bit 3: receive queue at its threshold
  - bit 4: bus idle
  - bit 5: addressed as slave
  - bit 6: no longer addressed as slave
  - bit 7: transmit queue half empty
- R3: A write to the status register (address 0) clears the status bits whose write-data bits in [7:0] are one. All other status bits keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A read of the status register returns the latched bits in [7:0], with zeros above them, whatever the mask register holds.
- R6: The mask register (address 1) stores write-data bits [7:0] and reads them back, with zeros in [31:8].
- R7: The gate register (address 2) stores only write-data bit 31. A read returns that bit in position 31 and zero in every other position.
- R8: `irq` is high exactly when the gate bit is set and at least one status bit is set together with its mask bit.
- R9: Writing exactly 0x0000000A to the key register (address 3) clears the status, mask and gate registers at that clock edge. It also drives `soft_rst_o` high for exactly the one cycle that follows.
- R10: Writing any other value to the key register changes no register and does not pulse `soft_rst_o`. The key register always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 8 | One-cycle event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 status, 1 mask, 2 gate, 3 key |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt line to the host |
| soft_rst_o | output | 1 | One-cycle reset pulse to the other controller blocks |

## Verification
The bench covers the corner cases below, each paired with the fault it would expose:
- **Event and clear on the same bit in the same cycle.** A design that lets the clear win would silently lose an event.
- **Partial clear masks.** A design that clears the whole register, or inverts the mask, would disturb bits that were not targeted.
- **Gate data with bit 31 low and the lower bits high.** A design that ORs the whole word into the gate would keep the line active.
- **Key values close to the real one, such as 0x5 and 0x1A.** A loose compare would reset the block by accident.
- **The cycle right after a valid key write.** A design that delays the clear, or stretches the pulse, would show stale registers or a two-cycle reset.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int          HUB_SRC    = 8;
  localparam int          HUB_DATA_W = 32;
  localparam int          HUB_ADDR_W = 2;
  localparam int          HUB_GATE_BIT = 31;
  localparam logic [31:0] HUB_RST_KEY  = 32'h0000_000A;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_GATE = 2'd2,
    SEL_KEY  = 2'd3
  } reg_sel_e;

  // Sticky bit update: an incoming event dominates a clear request.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

  // A source is pending when latched and unmasked; the gate qualifies all.
  function automatic logic line_active(input logic gate, input logic any_pend);
    return gate & any_pend;
  endfunction
endpackage

// File: rtl/irq_hub_status.sv
module irq_hub_status
  import irq_hub_pkg::*;
#(
  parameter int N_SRC = HUB_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic [N_SRC-1:0] evt_in,
  input  logic             clr_we,
  input  logic [N_SRC-1:0] clr_mask,
  output logic [N_SRC-1:0] stat_q
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stat_q[i] <= 1'b0;
      else if (wipe) stat_q[i] <= 1'b0;
      else           stat_q[i] <= sticky_next(stat_q[i], evt_in[i], clr_we & clr_mask[i]);
    end
  end

  // R2: a pulse latches its bit at the next edge
  assert_evt_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0 && !wipe) |=> ((stat_q & $past(evt_in)) == $past(evt_in)));

  // R3: a clearing write with no events leaves exactly the unmasked bits
  assert_clear_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && evt_in == '0 && !wipe) |=> (stat_q == ($past(stat_q) & ~$past(clr_mask))));

  // R4: event wins against a simultaneous clear
  assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (evt_in & clr_mask) != '0 && !wipe)
      |=> ((stat_q & $past(evt_in & clr_mask)) == $past(evt_in & clr_mask)));
endmodule

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
#(
  parameter int N_SRC  = HUB_SRC,
  parameter int DATA_W = HUB_DATA_W,
  parameter int ADDR_W = HUB_ADDR_W
) (
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [N_SRC-1:0]  stat_q,
  input  logic [N_SRC-1:0]  mask_q,
  input  logic              gate_q,
  output logic              stat_we,
  output logic              mask_we,
  output logic              gate_we,
  output logic              key_match,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int PAD_W = DATA_W - N_SRC;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr[1:0]);

  assign stat_we   = reg_we && sel == SEL_STAT;
  assign mask_we   = reg_we && sel == SEL_MASK;
  assign gate_we   = reg_we && sel == SEL_GATE;
  assign key_match = reg_we && sel == SEL_KEY && reg_wdata == DATA_W'(HUB_RST_KEY);

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_STAT: reg_rdata = {{PAD_W{1'b0}}, stat_q};
      SEL_MASK: reg_rdata = {{PAD_W{1'b0}}, mask_q};
      SEL_GATE: reg_rdata[HUB_GATE_BIT] = gate_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int N_SRC  = HUB_SRC,
  parameter int DATA_W = HUB_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              gate_we,
  input  logic              key_match,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_SRC-1:0]  mask_q,
  output logic              gate_q,
  output logic              soft_rst_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      gate_q     <= 1'b0;
      soft_rst_q <= 1'b0;
    end else begin
      soft_rst_q <= key_match;
      if (key_match) begin
        mask_q <= '0;
        gate_q <= 1'b0;
      end else begin
        if (mask_we) mask_q <= wdata[N_SRC-1:0];
        if (gate_we) gate_q <= wdata[HUB_GATE_BIT];
      end
    end
  end

  // R9: the reset pulse lasts one cycle
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_q |=> !soft_rst_q);

  // R9: control registers are empty while the pulse is out
  assert_ctrl_wiped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_q |-> (mask_q == '0 && !gate_q));
endmodule

// File: rtl/i2c_irq_hub.sv
module i2c_irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC  = HUB_SRC,
  parameter int DATA_W = HUB_DATA_W,
  parameter int ADDR_W = HUB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_pulse,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              soft_rst_o
);
  logic [N_SRC-1:0] stat_q, mask_q, pend_vec;
  logic             gate_q, stat_we, mask_we, gate_we, key_match;

  irq_hub_decode #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .stat_q(stat_q), .mask_q(mask_q), .gate_q(gate_q),
    .stat_we(stat_we), .mask_we(mask_we), .gate_we(gate_we),
    .key_match(key_match), .reg_rdata(reg_rdata));

  irq_hub_status #(.N_SRC(N_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .wipe(key_match), .evt_in(evt_pulse),
    .clr_we(stat_we), .clr_mask(reg_wdata[N_SRC-1:0]), .stat_q(stat_q));

  irq_hub_ctrl #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .gate_we(gate_we),
    .key_match(key_match), .wdata(reg_wdata),
    .mask_q(mask_q), .gate_q(gate_q), .soft_rst_q(soft_rst_o));

  assign pend_vec = stat_q & mask_q;
  assign irq      = line_active(gate_q, |pend_vec);

  // R10: a wrong key never produces the reset pulse
  assert_bad_key_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(SEL_KEY) && reg_wdata != DATA_W'(HUB_RST_KEY)) |=> !soft_rst_o);

  // R9: status is empty while the pulse is out
  assert_stat_wiped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (stat_q == '0 && !irq));
endmodule

// File: tb/tb_i2c_irq_hub.sv
module tb_i2c_irq_hub;
  localparam int PER = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_pulse = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, soft_rst_o;

  i2c_irq_hub dut (.*);

  always #(PER/2) clk = ~clk;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event  sample_ev;
  int    n_chk = 0, n_fail = 0;
  bit    finished = 1'b0;

  // model state
  logic [7:0] m_stat = '0, m_mask = '0;
  logic       m_gate = 1'b0;

  // monitor: pops expected items and compares to the ports
  initial forever begin
    @(sample_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = {31'b0, irq};
        default: act = {31'b0, soft_rst_o};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int kind, input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
    #3;
  endtask

  function automatic logic [31:0] exp_irq();
    return {31'b0, m_gate & |(m_stat & m_mask)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
    m_stat = m_stat | m;
  endtask

  initial begin
    #(PER * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_val(0, 2'd0, 32'h0, "R1 status");
    expect_val(0, 2'd1, 32'h0, "R1 mask");
    expect_val(0, 2'd2, 32'h0, "R1 gate");
    expect_val(1, 2'd0, 32'h0, "R1 irq");
    expect_val(2, 2'd0, 32'h0, "R1 soft_rst");

    // R2 latching and stickiness
    pulse(8'h01);
    expect_val(0, 2'd0, 32'h01, "R2 bit0 latch");
    pulse(8'h80);
    repeat (3) @(negedge clk);
    expect_val(0, 2'd0, 32'h81, "R2 sticky bits");
    // R5 raw status with mask zero
    expect_val(0, 2'd0, 32'h81, "R5 raw read");

    // R6 mask, R8 gate off
    wr(2'd1, 32'hFFFF_FF01); m_mask = 8'h01;
    expect_val(0, 2'd1, 32'h01, "R6 mask readback");
    expect_val(1, 2'd0, exp_irq(), "R8 gate off");
    // R7 gate bit 31
    wr(2'd2, 32'hFFFF_FFFF); m_gate = 1'b1;
    expect_val(0, 2'd2, 32'h8000_0000, "R7 gate readback");
    expect_val(1, 2'd0, exp_irq(), "R8 irq high");

    // R3 clear bit0
    wr(2'd0, 32'h01); m_stat = m_stat & ~8'h01;
    expect_val(0, 2'd0, 32'h80, "R3 partial clear");
    expect_val(1, 2'd0, exp_irq(), "R8 masked source only");
    wr(2'd1, 32'hFF); m_mask = 8'hFF;
    expect_val(1, 2'd0, exp_irq(), "R8 unmasked");
    wr(2'd2, 32'h7FFF_FFFF); m_gate = 1'b0;
    expect_val(0, 2'd2, 32'h0, "R7 low bits ignored");
    expect_val(1, 2'd0, exp_irq(), "R8 gate cleared");

    // R3 clear leaves others
    pulse(8'h3C);
    wr(2'd0, 32'h0C); m_stat = m_stat & ~8'h0C;
    expect_val(0, 2'd0, {24'b0, m_stat}, "R3 clear keeps others");

    // R4 event vs clear same cycle
    @(negedge clk);
    evt_pulse = 8'h11; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h90;
    @(negedge clk);
    evt_pulse = '0; reg_we = 1'b0;
    m_stat = (m_stat & ~8'h90) | 8'h11;
    expect_val(0, 2'd0, {24'b0, m_stat}, "R4 set wins");

    // R10 wrong keys
    wr(2'd2, 32'h8000_0000); m_gate = 1'b1;
    wr(2'd3, 32'h5);
    expect_val(2, 2'd0, 32'h0, "R10 key 0x5 no pulse");
    wr(2'd3, 32'h1A);
    expect_val(2, 2'd0, 32'h0, "R10 key 0x1A no pulse");
    expect_val(0, 2'd0, {24'b0, m_stat}, "R10 status kept");
    expect_val(0, 2'd1, {24'b0, m_mask}, "R10 mask kept");
    expect_val(0, 2'd2, 32'h8000_0000, "R10 gate kept");
    expect_val(0, 2'd3, 32'h0, "R10 key reads zero");
    expect_val(1, 2'd0, exp_irq(), "R10 irq kept");

    // R9 valid key
    wr(2'd3, 32'hA); m_stat = '0; m_mask = '0; m_gate = 1'b0;
    expect_val(2, 2'd0, 32'h1, "R9 pulse high");
    expect_val(0, 2'd0, 32'h0, "R9 status wiped");
    expect_val(0, 2'd1, 32'h0, "R9 mask wiped");
    expect_val(0, 2'd2, 32'h0, "R9 gate wiped");
    expect_val(1, 2'd0, 32'h0, "R9 irq low");
    @(negedge clk);
    expect_val(2, 2'd0, 32'h0, "R9 pulse one cycle");

    // R2 latching after soft reset
    pulse(8'h40);
    expect_val(0, 2'd0, 32'h40, "R2 latch after soft reset");

    #5;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule